// File: doc/BRIEF.md
# UART Channel Diagnostic Mode Router

This block sits between one UART channel's serial transmitter, serial receiver, the CPU-side transmit and receive data streams, and the channel's TxD and RxD pins. A two-bit mode selects how these are wired together. The four choices are ordinary operation, automatic echo, internal (local) loopback and remote loopback. In the two echo-style modes the block re-times the incoming line on the receiver's bit tick and drives it out on TxD. Every bit is forwarded as it arrived, including parity, stop bits and a held break level. No bit is regenerated.

The block also gates what the CPU sees, which depends on the mode. In echo mode the CPU cannot reach the transmitter and the transmitter status flags read inactive. In remote loopback received characters are dropped before the CPU and all error status is forced off. In local loopback the transmitter's serial output and bit tick feed the receiver, TxD is held at mark and the RxD pin is ignored.

A mode write is not applied immediately. It is parked as pending and takes effect only on a cycle where the receiver and the transmitter both report idle, so a character in flight is never cut in half. The CPU-side data paths are valid/ready streams. The router passes valid, data and ready straight through (combinationally) in modes where the path is open. A source must hold valid and data stable until ready is seen, and ready from the sink is returned unchanged, so back-pressure reaches the source in the same cycle.

Top module: `uart_diag_router`

## Requirements
- R1: After reset the active mode is 00 (normal), no mode change is pending and TxD is high.
- R2: A mode write with code 00 = normal, 01 = echo, 10 = local loopback or 11 = remote loopback sets `mode_pending`. The code becomes `mode_active` on the first clock edge after the write at which `rx_core_idle` and `tx_core_idle` are both 1, and `mode_pending` then clears. A later write made while the change is still pending replaces the pending code.
- R3: In normal mode TxD follows the transmitter serial output. The receiver serial input is RxD after a two-flop synchronizer, and the receiver tick is `rx_bit_tick`. Both CPU streams pass valid, data and ready unchanged, including ready low as back-pressure.
- R4: In echo and remote modes TxD shows the synchronized RxD value captured at the last clock edge where `rx_bit_tick` was 1. It holds between ticks, so a held low level (a break) stays low on TxD for as long as it is received.
- R5: In echo mode `cpu_tx_ready`, `txc_valid`, `tx_rdy_flag` and `tx_idle_flag` are all 0, whatever the transmitter and CPU drive.
- R6: In echo mode the receive stream and the parity/framing error flags pass through, and both receiver check enables are 1.
- R7: In local loopback TxD is 1, the receiver serial input is the transmitter serial output and the receiver tick is `tx_bit_tick`. Changes on RxD have no effect on any output.
- R8: In remote loopback `cpu_rx_valid` is 0 and `rxc_ready` is 1 (received characters are discarded). Both error flags and both check enables are 0, and the CPU transmit stream still passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_valid | input | 1 | One-cycle mode write strobe |
| mode_wr_data | input | 2 | Requested mode code |
| mode_active | output | 2 | Mode currently in force |
| mode_pending | output | 1 | A written mode waits for both engines to go idle |
| rxd_pin | input | 1 | Serial line from the far end (asynchronous) |
| txd_pin | output | 1 | Serial line to the far end |
| tx_ser | input | 1 | Transmitter engine serial output |
| tx_bit_tick | input | 1 | Transmitter 1x bit tick |
| tx_core_idle | input | 1 | Transmitter has no character in progress |
| tx_core_rdy | input | 1 | Transmitter can accept a character |
| rx_bit_tick | input | 1 | Receiver 1x bit tick |
| rx_core_idle | input | 1 | Receiver has no character in progress |
| rx_core_ser | output | 1 | Serial input to the receiver engine |
| rx_core_tick | output | 1 | Bit tick given to the receiver engine |
| rx_par_err_in | input | 1 | Parity error from the receiver |
| rx_frm_err_in | input | 1 | Framing error from the receiver |
| rx_par_chk_en | output | 1 | Receiver should check parity |
| rx_frm_chk_en | output | 1 | Receiver should check framing |
| par_err_flag | output | 1 | Parity error status to the CPU |
| frm_err_flag | output | 1 | Framing error status to the CPU |
| tx_rdy_flag | output | 1 | Transmitter-ready status to the CPU |
| tx_idle_flag | output | 1 | Transmitter-idle status to the CPU |
| cpu_tx_valid | input | 1 | CPU transmit stream valid |
| cpu_tx_ready | output | 1 | CPU transmit stream ready |
| cpu_tx_data | input | DATA_W | CPU transmit character |
| txc_valid | output | 1 | Valid to the transmitter engine |
| txc_ready | input | 1 | Ready from the transmitter engine |
| txc_data | output | DATA_W | Character to the transmitter engine |
| rxc_valid | input | 1 | Receiver engine character valid |
| rxc_ready | output | 1 | Ready to the receiver engine |
| rxc_data | input | DATA_W | Received character |
| cpu_rx_valid | output | 1 | CPU receive stream valid |
| cpu_rx_ready | input | 1 | CPU receive stream ready |
| cpu_rx_data | output | DATA_W | Character to the CPU |

## Verification
The hardest case to reach from the ports is a mode write that arrives while one engine is busy and is then overwritten before that engine goes idle. The stimulus holds `tx_core_idle` low and issues two mode writes. It confirms the mode does not move and `mode_pending` stays set, then releases idle and checks that only the second code appears, exactly one edge later. The second hard case is showing the re-timing window in echo mode. The bench changes RxD, keeps `rx_bit_tick` low long enough for the synchronizer to settle, and confirms TxD has not moved. It then pulses a single tick and checks the new level, and it holds RxD low across several ticks to show a break echoed as a steady low.

// File: rtl/uart_diag_pkg.sv
package uart_diag_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ECHO   = 2'b01,
    MODE_LOCAL  = 2'b10,
    MODE_REMOTE = 2'b11
  } diag_mode_e;
endpackage

// File: rtl/uart_diag_mode_ctrl.sv
module uart_diag_mode_ctrl
  import uart_diag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [1:0] wr_mode,
  input  logic       rx_idle,
  input  logic       tx_idle,
  output diag_mode_e mode_q,
  output logic       pend_q
);
  logic [1:0] pend_mode_q;
  logic       both_idle;

  assign both_idle = rx_idle && tx_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= MODE_NORMAL;
      pend_q      <= 1'b0;
      pend_mode_q <= 2'b00;
    end else if (wr_valid) begin
      pend_q      <= 1'b1;
      pend_mode_q <= wr_mode;
    end else if (pend_q && both_idle) begin
      mode_q <= diag_mode_e'(pend_mode_q);
      pend_q <= 1'b0;
    end
  end

  // R2
  mode_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(both_idle));

  // R2
  pend_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && both_idle && !wr_valid) |=> !pend_q);

  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !both_idle) |=> (pend_q && $stable(mode_q)));
endmodule

// File: rtl/uart_diag_echo_retimer.sv
module uart_diag_echo_retimer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_async,
  input  logic rx_tick,
  output logic rxd_sync,
  output logic echo_bit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          echo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[LAST-1:0], rxd_async};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       echo_q <= 1'b1;
    else if (rx_tick) echo_q <= sync_q[LAST];
  end

  assign rxd_sync = sync_q[LAST];
  assign echo_bit = echo_q;

  // R4
  echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_tick |=> $stable(echo_bit));

  // R4
  echo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |=> (echo_bit == $past(rxd_sync)));
endmodule

// File: rtl/uart_diag_path_gate.sv
module uart_diag_path_gate
  import uart_diag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  diag_mode_e        mode,
  input  logic              rxd_sync,
  input  logic              echo_bit,
  input  logic              tx_ser,
  input  logic              tx_bit_tick,
  input  logic              rx_bit_tick,
  input  logic              tx_core_idle,
  input  logic              tx_core_rdy,
  input  logic              rx_par_err_in,
  input  logic              rx_frm_err_in,
  output logic              txd_pin,
  output logic              rx_core_ser,
  output logic              rx_core_tick,
  output logic              rx_par_chk_en,
  output logic              rx_frm_chk_en,
  output logic              par_err_flag,
  output logic              frm_err_flag,
  output logic              tx_rdy_flag,
  output logic              tx_idle_flag,
  input  logic              cpu_tx_valid,
  output logic              cpu_tx_ready,
  input  logic [DATA_W-1:0] cpu_tx_data,
  output logic              txc_valid,
  input  logic              txc_ready,
  output logic [DATA_W-1:0] txc_data,
  input  logic              rxc_valid,
  output logic              rxc_ready,
  input  logic [DATA_W-1:0] rxc_data,
  output logic              cpu_rx_valid,
  input  logic              cpu_rx_ready,
  output logic [DATA_W-1:0] cpu_rx_data
);
  logic is_echo, is_local, is_remote, is_retx;

  always_comb begin
    is_echo   = (mode == MODE_ECHO);
    is_local  = (mode == MODE_LOCAL);
    is_remote = (mode == MODE_REMOTE);
    is_retx   = is_echo || is_remote;

    txd_pin      = is_local ? 1'b1 : (is_retx ? echo_bit : tx_ser);
    rx_core_ser  = is_local ? tx_ser : rxd_sync;
    rx_core_tick = is_local ? tx_bit_tick : rx_bit_tick;

    cpu_tx_ready = txc_ready && !is_echo;
    txc_valid    = cpu_tx_valid && !is_echo;
    txc_data     = cpu_tx_data;
    tx_rdy_flag  = tx_core_rdy && !is_echo;
    tx_idle_flag = tx_core_idle && !is_echo;

    cpu_rx_valid  = rxc_valid && !is_remote;
    rxc_ready     = cpu_rx_ready || is_remote;
    cpu_rx_data   = rxc_data;
    par_err_flag  = rx_par_err_in && !is_remote;
    frm_err_flag  = rx_frm_err_in && !is_remote;
    rx_par_chk_en = !is_remote;
    rx_frm_chk_en = !is_remote;
  end

  // R5
  echo_tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ECHO) |-> (!cpu_tx_ready && !txc_valid && !tx_rdy_flag && !tx_idle_flag));

  // R8
  remote_rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_REMOTE) |-> (!cpu_rx_valid && rxc_ready && !par_err_flag && !frm_err_flag));

  // R7
  local_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOCAL) |-> (txd_pin && rx_core_ser == tx_ser));
endmodule

// File: rtl/uart_diag_router.sv
module uart_diag_router
  import uart_diag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_valid,
  input  logic [1:0]        mode_wr_data,
  output logic [1:0]        mode_active,
  output logic              mode_pending,
  input  logic              rxd_pin,
  output logic              txd_pin,
  input  logic              tx_ser,
  input  logic              tx_bit_tick,
  input  logic              tx_core_idle,
  input  logic              tx_core_rdy,
  input  logic              rx_bit_tick,
  input  logic              rx_core_idle,
  output logic              rx_core_ser,
  output logic              rx_core_tick,
  input  logic              rx_par_err_in,
  input  logic              rx_frm_err_in,
  output logic              rx_par_chk_en,
  output logic              rx_frm_chk_en,
  output logic              par_err_flag,
  output logic              frm_err_flag,
  output logic              tx_rdy_flag,
  output logic              tx_idle_flag,
  input  logic              cpu_tx_valid,
  output logic              cpu_tx_ready,
  input  logic [DATA_W-1:0] cpu_tx_data,
  output logic              txc_valid,
  input  logic              txc_ready,
  output logic [DATA_W-1:0] txc_data,
  input  logic              rxc_valid,
  output logic              rxc_ready,
  input  logic [DATA_W-1:0] rxc_data,
  output logic              cpu_rx_valid,
  input  logic              cpu_rx_ready,
  output logic [DATA_W-1:0] cpu_rx_data
);
  diag_mode_e mode_q;
  logic       rxd_sync, echo_bit;

  uart_diag_mode_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (mode_wr_valid),
    .wr_mode  (mode_wr_data),
    .rx_idle  (rx_core_idle),
    .tx_idle  (tx_core_idle),
    .mode_q   (mode_q),
    .pend_q   (mode_pending)
  );

  uart_diag_echo_retimer #(.SYNC_STAGES(SYNC_STAGES)) u_retime (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd_async (rxd_pin),
    .rx_tick   (rx_bit_tick),
    .rxd_sync  (rxd_sync),
    .echo_bit  (echo_bit)
  );

  uart_diag_path_gate #(.DATA_W(DATA_W)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode_q),
    .rxd_sync      (rxd_sync),
    .echo_bit      (echo_bit),
    .tx_ser        (tx_ser),
    .tx_bit_tick   (tx_bit_tick),
    .rx_bit_tick   (rx_bit_tick),
    .tx_core_idle  (tx_core_idle),
    .tx_core_rdy   (tx_core_rdy),
    .rx_par_err_in (rx_par_err_in),
    .rx_frm_err_in (rx_frm_err_in),
    .txd_pin       (txd_pin),
    .rx_core_ser   (rx_core_ser),
    .rx_core_tick  (rx_core_tick),
    .rx_par_chk_en (rx_par_chk_en),
    .rx_frm_chk_en (rx_frm_chk_en),
    .par_err_flag  (par_err_flag),
    .frm_err_flag  (frm_err_flag),
    .tx_rdy_flag   (tx_rdy_flag),
    .tx_idle_flag  (tx_idle_flag),
    .cpu_tx_valid  (cpu_tx_valid),
    .cpu_tx_ready  (cpu_tx_ready),
    .cpu_tx_data   (cpu_tx_data),
    .txc_valid     (txc_valid),
    .txc_ready     (txc_ready),
    .txc_data      (txc_data),
    .rxc_valid     (rxc_valid),
    .rxc_ready     (rxc_ready),
    .rxc_data      (rxc_data),
    .cpu_rx_valid  (cpu_rx_valid),
    .cpu_rx_ready  (cpu_rx_ready),
    .cpu_rx_data   (cpu_rx_data)
  );

  assign mode_active = mode_q;

  // R1
  reset_mark_chk: assert property (@(posedge clk)
    !rst_n |=> (mode_active == 2'b00 && !mode_pending && txd_pin));
endmodule

// File: tb/uart_diag_router_tb_top.sv
`timescale 1ns/1ps
module uart_diag_router_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          mode_wr_valid = 0;
  logic [1:0]    mode_wr_data = 0;
  logic [1:0]    mode_active;
  logic          mode_pending;
  logic          rxd_pin = 1, txd_pin;
  logic          tx_ser = 1, tx_bit_tick = 0, tx_core_idle = 1, tx_core_rdy = 1;
  logic          rx_bit_tick = 0, rx_core_idle = 1;
  logic          rx_core_ser, rx_core_tick;
  logic          rx_par_err_in = 0, rx_frm_err_in = 0;
  logic          rx_par_chk_en, rx_frm_chk_en, par_err_flag, frm_err_flag;
  logic          tx_rdy_flag, tx_idle_flag;
  logic          cpu_tx_valid = 0, cpu_tx_ready;
  logic [DW-1:0] cpu_tx_data = 0;
  logic          txc_valid, txc_ready = 1;
  logic [DW-1:0] txc_data;
  logic          rxc_valid = 0, rxc_ready;
  logic [DW-1:0] rxc_data = 0;
  logic          cpu_rx_valid, cpu_rx_ready = 1;
  logic [DW-1:0] cpu_rx_data;

  int n_chk = 0;
  int n_fail = 0;

  uart_diag_router #(.DATA_W(DW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic write_mode(input logic [1:0] m);
    @(negedge clk); mode_wr_valid = 1; mode_wr_data = m;
    @(negedge clk); mode_wr_valid = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    write_mode(m);
    @(negedge clk);
    chk("R2 mode applied", {30'd0, mode_active}, {30'd0, m});
  endtask

  task automatic tick_rx();
    repeat (3) @(negedge clk);
    rx_bit_tick = 1;
    @(negedge clk); rx_bit_tick = 0;
  endtask

  task automatic t_reset();
    chk("R1 mode", {30'd0, mode_active}, 0);
    chk("R1 pending", {31'd0, mode_pending}, 0);
    chk("R1 txd", {31'd0, txd_pin}, 1);
  endtask

  task automatic t_normal();
    tx_ser = 0; #1;
    chk("R3 txd follows tx", {31'd0, txd_pin}, 0);
    tx_ser = 1;
    rxd_pin = 0;
    repeat (2) @(negedge clk);
    chk("R3 rx serial synced", {31'd0, rx_core_ser}, 0);
    rxd_pin = 1;
    rx_bit_tick = 1; #1;
    chk("R3 rx tick", {31'd0, rx_core_tick}, 1);
    rx_bit_tick = 0;
    cpu_tx_valid = 1; cpu_tx_data = 8'h3C; txc_ready = 0; #1;
    chk("R3 tx stream", {22'd0, txc_valid, cpu_tx_ready, txc_data}, {22'd0, 2'b10, 8'h3C});
    rxc_valid = 1; rxc_data = 8'h5A; cpu_rx_ready = 0; #1;
    chk("R3 rx backpressure", {22'd0, cpu_rx_valid, rxc_ready, cpu_rx_data}, {22'd0, 2'b10, 8'h5A});
    cpu_tx_valid = 0; txc_ready = 1; rxc_valid = 0; cpu_rx_ready = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pending();
    tx_core_idle = 0;
    write_mode(2'b01);
    repeat (3) @(negedge clk);
    chk("R2 held while busy", {30'd0, mode_active}, 0);
    chk("R2 pending set", {31'd0, mode_pending}, 1);
    write_mode(2'b11);
    @(negedge clk);
    chk("R2 still held", {30'd0, mode_active}, 0);
    tx_core_idle = 1;
    @(negedge clk);
    chk("R2 latest write wins", {30'd0, mode_active}, 2'b11);
    chk("R2 pending cleared", {31'd0, mode_pending}, 0);
  endtask

  task automatic t_remote();
    rxc_valid = 1; rxc_data = 8'h77; cpu_rx_ready = 0;
    rx_par_err_in = 1; rx_frm_err_in = 1; #1;
    chk("R8 rx dropped", {30'd0, cpu_rx_valid, rxc_ready}, 2'b01);
    chk("R8 errors off", {28'd0, par_err_flag, frm_err_flag, rx_par_chk_en, rx_frm_chk_en}, 0);
    cpu_tx_valid = 1; #1;
    chk("R8 tx stream passes", {30'd0, txc_valid, cpu_tx_ready}, 2'b11);
    rxc_valid = 0; cpu_rx_ready = 1; rx_par_err_in = 0; rx_frm_err_in = 0; cpu_tx_valid = 0;
    rxd_pin = 0; tick_rx();
    chk("R4 remote retime", {31'd0, txd_pin}, 0);
    rxd_pin = 1; tick_rx();
    chk("R4 remote retime high", {31'd0, txd_pin}, 1);
  endtask

  task automatic t_echo();
    rxd_pin = 0;
    repeat (4) @(negedge clk);
    chk("R4 holds without tick", {31'd0, txd_pin}, 1);
    rx_bit_tick = 1; @(negedge clk); rx_bit_tick = 0;
    chk("R4 captured on tick", {31'd0, txd_pin}, 0);
    tick_rx(); tick_rx();
    chk("R4 break echoed", {31'd0, txd_pin}, 0);
    rxd_pin = 1; tick_rx();
    chk("R4 break ends", {31'd0, txd_pin}, 1);
    tx_ser = 0; #1;
    chk("R4 tx core not on pin", {31'd0, txd_pin}, 1);
    tx_ser = 1;
    cpu_tx_valid = 1; txc_ready = 1; tx_core_rdy = 1; #1;
    chk("R5 tx blocked", {28'd0, cpu_tx_ready, txc_valid, tx_rdy_flag, tx_idle_flag}, 0);
    cpu_tx_valid = 0;
    rxc_valid = 1; rxc_data = 8'hA5; rx_par_err_in = 1; rx_frm_err_in = 1; #1;
    chk("R6 rx passes", {23'd0, cpu_rx_valid, cpu_rx_data}, {23'd0, 1'b1, 8'hA5});
    chk("R6 errors pass", {28'd0, par_err_flag, frm_err_flag, rx_par_chk_en, rx_frm_chk_en}, 4'hF);
    rxc_valid = 0; rx_par_err_in = 0; rx_frm_err_in = 0;
  endtask

  task automatic t_local();
    tx_ser = 0; #1;
    chk("R7 txd mark", {31'd0, txd_pin}, 1);
    chk("R7 tx looped to rx", {31'd0, rx_core_ser}, 0);
    tx_bit_tick = 1; rx_bit_tick = 0; #1;
    chk("R7 rx uses tx tick", {31'd0, rx_core_tick}, 1);
    tx_bit_tick = 0; rx_bit_tick = 1; #1;
    chk("R7 rx tick ignored", {31'd0, rx_core_tick}, 0);
    rx_bit_tick = 0;
    rxd_pin = 0;
    repeat (4) @(negedge clk);
    chk("R7 rxd ignored", {30'd0, txd_pin, rx_core_ser}, 2'b10);
    tx_ser = 1; rxd_pin = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_pending();
    t_remote();
    set_mode(2'b01);
    t_echo();
    set_mode(2'b10);
    t_local();
    set_mode(2'b00);
    report();
    $finish;
  end
endmodule